// File: doc/BRIEF.md
# Four-Phase Handshake Relay Controller

This controller bridges two return-to-zero request/acknowledge channels. A requester on the upstream side raises `upReq`. The controller then runs one full downstream cycle: it raises `dnReq`, waits for `dnAck` to go high, drops `dnReq`, and waits for `dnAck` to go low. Only after that does it raise `upAck`. When the requester lowers `upReq`, the controller drops `upAck`, spends one cycle in a return phase, and goes back to idle. Every event on one channel is therefore strictly ordered against every event on the other.

The controller is a clocked five-phase machine with a synchronous, active-high reset. Both inputs are expected to be synchronised to `clk` already. It handles one transaction at a time.

An input that moves in a phase not waiting for it sets a sticky `protoErr` flag, and the sequencing carries on. Two cases count: a `dnAck` edge that no phase expects, and `upReq` dropping before `upAck` has been given. Only reset clears the flag.

Top module: `handshake_relay`

## Requirements
- R1: While `rst` is high at a clock edge, `upAck`, `dnReq` and `protoErr` are all low after that edge, and the controller is idle.
- R2: When the controller is idle and `upReq` is high at a clock edge, `dnReq` is high after that same edge.
- R3: `dnReq` stays high until a clock edge at which `dnAck` is high, and goes low at that edge.
- R4: After `dnReq` has fallen, `upAck` stays low until a clock edge at which `dnAck` is low, and goes high at that edge.
- R5: `upAck` stays high until a clock edge at which `upReq` is low, and goes low at that edge.
- R6: After `upAck` falls, the controller spends exactly one cycle in its return phase. A request that is already high answers with `dnReq` at the second edge after `upAck` fell, not the first.
- R7: `upAck` and `dnReq` are never high together, and no clock edge changes both of them.
- R8: A rising edge of `dnAck` while no downstream acknowledge is awaited, or a falling edge of `dnAck` while its release is not awaited, sets `protoErr` at that edge. The flag stays set until reset, and a legal transaction never sets it.
- R9: `upReq` falling while `dnReq` is high, or while the controller waits for `dnAck` to fall, sets `protoErr` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| upReq | input | 1 | Upstream request, already synchronised |
| dnAck | input | 1 | Downstream acknowledge, already synchronised |
| upAck | output | 1 | Upstream acknowledge, registered |
| dnReq | output | 1 | Downstream request, registered |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
The ordering assertions assume that both neighbours obey the four-phase rules: `upReq` is not withdrawn before `upAck`, and `dnAck` moves only in answer to `dnReq`. Under that assumption, every output edge must follow from the input level seen at the previous edge. The sweep drives inputs only at falling clock edges, and only in the phase that expects them, with response delays of zero to three cycles. Protocol violations are injected only after a reset, in their own short sequences, and only the error flag and the outputs are checked against them. The exclusivity and stickiness properties hold for any input pattern.

// File: rtl/handshake_relay_pkg.sv
package handshake_relay_pkg;

  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE   = 3'd0,
    PH_DN_REQ = 3'd1,
    PH_DN_REL = 3'd2,
    PH_UP_ACK = 3'd3,
    PH_RETURN = 3'd4
  } phase_e;

  typedef struct packed {
    logic raiseDn;
    logic dropDn;
    logic raiseUp;
    logic dropUp;
    logic expectDnRise;
    logic expectDnFall;
    logic upHoldRequired;
  } strobe_t;

endpackage

// File: rtl/handshake_relay_ctrl.sv
module handshake_relay_ctrl
  import handshake_relay_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    upReq,
  input  logic    dnAck,
  output strobe_t strb
);

  phase_e phase;
  phase_e phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    unique case (phase)
      PH_IDLE: begin
        if (upReq) begin
          strb.raiseDn = 1'b1;
          phaseNext    = PH_DN_REQ;
        end
      end
      PH_DN_REQ: begin
        strb.expectDnRise   = 1'b1;
        strb.upHoldRequired = 1'b1;
        if (dnAck) begin
          strb.dropDn = 1'b1;
          phaseNext   = PH_DN_REL;
        end
      end
      PH_DN_REL: begin
        strb.expectDnFall   = 1'b1;
        strb.upHoldRequired = 1'b1;
        if (!dnAck) begin
          strb.raiseUp = 1'b1;
          phaseNext    = PH_UP_ACK;
        end
      end
      PH_UP_ACK: begin
        if (!upReq) begin
          strb.dropUp = 1'b1;
          phaseNext   = PH_RETURN;
        end
      end
      PH_RETURN: begin
        phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/handshake_relay_dp.sv
module handshake_relay_dp
  import handshake_relay_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    upReq,
  input  logic    dnAck,
  input  strobe_t strb,
  output logic    upAck,
  output logic    dnReq,
  output logic    protoErr
);

  logic upReqQ;
  logic dnAckQ;
  logic dnRise;
  logic dnFall;
  logic upFall;
  logic errHit;

  always_comb begin
    dnRise = dnAck & ~dnAckQ;
    dnFall = ~dnAck & dnAckQ;
    upFall = ~upReq & upReqQ;
    errHit = (dnRise & ~strb.expectDnRise)
           | (dnFall & ~strb.expectDnFall)
           | (upFall & strb.upHoldRequired);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upReqQ   <= 1'b0;
      dnAckQ   <= 1'b0;
      upAck    <= 1'b0;
      dnReq    <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      upReqQ <= upReq;
      dnAckQ <= dnAck;
      if (strb.raiseDn)      dnReq <= 1'b1;
      else if (strb.dropDn)  dnReq <= 1'b0;
      if (strb.raiseUp)      upAck <= 1'b1;
      else if (strb.dropUp)  upAck <= 1'b0;
      if (errHit)            protoErr <= 1'b1;
    end
  end

endmodule

// File: rtl/handshake_relay.sv
module handshake_relay
  import handshake_relay_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic upReq,
  input  logic dnAck,
  output logic upAck,
  output logic dnReq,
  output logic protoErr
);

  strobe_t strb;

  handshake_relay_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .upReq (upReq),
    .dnAck (dnAck),
    .strb  (strb)
  );

  handshake_relay_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .upReq    (upReq),
    .dnAck    (dnAck),
    .strb     (strb),
    .upAck    (upAck),
    .dnReq    (dnReq),
    .protoErr (protoErr)
  );

endmodule

// File: rtl/handshake_relay_chk.sv
module handshake_relay_chk (
  input logic clk,
  input logic rst,
  input logic upReq,
  input logic dnAck,
  input logic upAck,
  input logic dnReq,
  input logic protoErr
);

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!upAck && !dnReq && !protoErr));

  assert_dnreq_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dnReq) |-> ($past(upReq) && !$past(upAck)));

  assert_dnreq_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dnReq) |-> $past(dnAck));

  assert_upack_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(upAck) |-> (!$past(dnAck) && !$past(dnReq)));

  assert_upack_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(upAck) |-> !$past(upReq));

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(upAck && dnReq));

  assert_single_change_R7: assert property (@(posedge clk) disable iff (rst)
    !((upAck != $past(upAck)) && (dnReq != $past(dnReq))));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(protoErr) |-> protoErr);

endmodule

bind handshake_relay handshake_relay_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .upReq    (upReq),
  .dnAck    (dnAck),
  .upAck    (upAck),
  .dnReq    (dnReq),
  .protoErr (protoErr)
);

// File: tb/handshake_relay_tb.sv
module handshake_relay_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upReq = 1'b0;
  logic dnAck = 1'b0;
  logic upAck;
  logic dnReq;
  logic protoErr;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  handshake_relay u_dut (
    .clk      (clk),
    .rst      (rst),
    .upReq    (upReq),
    .dnAck    (dnAck),
    .upAck    (upAck),
    .dnReq    (dnReq),
    .protoErr (protoErr)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; upReq = 1'b0; dnAck = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Called at a negedge with the controller idle and both inputs low.
  task automatic runTxn(input int d, input bit backToBack);
    upReq = 1'b1;
    @(negedge clk);
    chk("R2", "dnReq after request", dnReq, 1'b1);
    chk("R7", "upAck low with dnReq", upAck, 1'b0);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk("R3", "dnReq held while waiting", dnReq, 1'b1);
    end
    dnAck = 1'b1;
    @(negedge clk);
    chk("R3", "dnReq drops on ack", dnReq, 1'b0);
    chk("R7", "upAck still low", upAck, 1'b0);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk("R4", "upAck waits for ack release", upAck, 1'b0);
    end
    dnAck = 1'b0;
    @(negedge clk);
    chk("R4", "upAck after ack release", upAck, 1'b1);
    chk("R7", "dnReq low with upAck", dnReq, 1'b0);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk("R5", "upAck held while request high", upAck, 1'b1);
    end
    upReq = 1'b0;
    @(negedge clk);
    chk("R5", "upAck drops on request release", upAck, 1'b0);
    if (backToBack) begin
      upReq = 1'b1;
      @(negedge clk);
      chk("R6", "return phase ignores request", dnReq, 1'b0);
      @(negedge clk);
      chk("R6", "request answered after return", dnReq, 1'b1);
      dnAck = 1'b1;
      @(negedge clk);
      dnAck = 1'b0;
      @(negedge clk);
      chk("R4", "second txn upAck", upAck, 1'b1);
      upReq = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R6", "idle dnReq low", dnReq, 1'b0);
    chk("R8", "no error on legal txn", protoErr, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "upAck in reset", upAck, 1'b0);
    chk("R1", "dnReq in reset", dnReq, 1'b0);
    chk("R1", "protoErr in reset", protoErr, 1'b0);
    doReset();
    chk("R1", "idle after reset", dnReq, 1'b0);

    for (int d = 0; d < 4; d++) runTxn(d, 1'b0);
    runTxn(1, 1'b1);
    runTxn(0, 1'b1);

    // R8: dnAck rise while idle
    doReset();
    dnAck = 1'b1;
    @(negedge clk);
    chk("R8", "stray dnAck rise in idle", protoErr, 1'b1);
    chk("R8", "no dnReq from stray ack", dnReq, 1'b0);
    dnAck = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "flag is sticky", protoErr, 1'b1);
    doReset();
    chk("R1", "reset clears flag", protoErr, 1'b0);

    // R8: dnAck rise while upAck is high
    upReq = 1'b1; @(negedge clk);
    dnAck = 1'b1; @(negedge clk);
    dnAck = 1'b0; @(negedge clk);
    chk("R8", "legal so far", protoErr, 1'b0);
    dnAck = 1'b1; @(negedge clk);
    chk("R8", "dnAck rise during upstream ack", protoErr, 1'b1);
    chk("R5", "upAck unaffected", upAck, 1'b1);

    // R9: upReq withdrawn while dnReq high
    doReset();
    upReq = 1'b1; @(negedge clk);
    chk("R2", "dnReq before withdrawal", dnReq, 1'b1);
    upReq = 1'b0; @(negedge clk);
    chk("R9", "early withdrawal with dnReq high", protoErr, 1'b1);

    // R9: upReq withdrawn while awaiting dnAck release
    doReset();
    upReq = 1'b1; @(negedge clk);
    dnAck = 1'b1; @(negedge clk);
    chk("R9", "no error before withdrawal", protoErr, 1'b0);
    upReq = 1'b0; @(negedge clk);
    chk("R9", "withdrawal awaiting release", protoErr, 1'b1);
    chk("R7", "upAck not given", upAck, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule